// File: doc/BRIEF.md
# Page-Mode Write Buffer Controller

This block is the write path of a page-mode nonvolatile memory model. A host gives one-cycle byte-load strobes, each with a 17-bit address and a data byte. The low seven address bits pick a slot in a 128-byte page buffer. The upper ten bits name the page. The page stays open for loading as long as each new byte follows the previous one within a load window. When a full window passes with no strobe, the block commits the whole buffer to the memory array in one wide write. It then stays busy for a fixed internal write time.

While busy, the block answers read strobes with a status byte. Bit 7 carries the complement of bit 7 of the last loaded byte. Bit 6 flips on each read. Slots the host did not load are written as erased bytes (0xFF). After the commit the buffer returns to the erased state, ready for the next page. Both intervals are parameters counted in clock cycles, so the real microsecond and millisecond figures map onto any clock rate.

Top module: `pagewr_ctrl`

## Requirements
- R1: After reset `busy_o` is 0, `arr_we_o` is 0 and `rd_status_o` is 0x00.
- R2: A load accepted while not busy stores `data_i` into buffer slot `addr_i[6:0]`. Slot i appears at `arr_data_o[8*i+7:8*i]` in the commit.
- R3: A load strobe that comes no more than LOAD_TMO_CYC clock edges after the previous accepted load keeps the page open. This holds even when it lands on the very edge at which the window would have expired. `busy_o` stays 0 in the cycle after any accepted load.
- R4: Let edge k carry the last accepted load, and let LOAD_TMO_CYC edges follow with no strobe. Then `busy_o` rises in the cycle after edge k+LOAD_TMO_CYC.
- R5: Every buffer slot not loaded since the previous commit is written as 0xFF.
- R6: Loading a slot a second time replaces its earlier value.
- R7: `arr_page_o` equals `addr_i[16:7]` of the last accepted load, even when earlier loads named other pages.
- R8: `busy_o` stays high for exactly WRITE_CYC cycles. `arr_we_o` is high for exactly one cycle, the last busy cycle, and carries the whole page.
- R9: While busy, `rd_status_o[7]` is the complement of bit 7 of the last loaded byte and bits 5:0 are 0. While not busy, `rd_status_o` is 0x00.
- R10: `rd_status_o[6]` is 0 in the first busy cycle of each write. It inverts after every clock edge that samples `rd_stb_i` high while busy.
- R11: While busy, load strobes are ignored. They change neither the buffer, the page, the busy duration nor the status. Read strobes while not busy have no effect.
- R12: After a commit, every buffer slot returns to 0xFF before the next page is loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_stb_i | input | 1 | One-cycle byte-load strobe |
| addr_i | input | ADDR_W (17) | Load address: page in [16:7], slot in [6:0] |
| data_i | input | 8 | Load data byte |
| rd_stb_i | input | 1 | Status read strobe |
| busy_o | output | 1 | Internal write in progress |
| rd_status_o | output | 8 | Polling status byte |
| arr_we_o | output | 1 | One-cycle array page write enable |
| arr_page_o | output | ADDR_W-OFF_W (10) | Page number written to the array |
| arr_data_o | output | 8*2^OFF_W (1024) | Whole page image, slot i in bits [8i+7:8i] |

## Verification
Two pairs of events can fall on the same clock edge, and each pair needs a defined winner.

The first pair is a load strobe and expiry of the load window. The bench places a load exactly LOAD_TMO_CYC edges after the previous one. It then expects `busy_o` to stay low and the late byte to appear in the committed page. Random gaps up to that limit cover the nearby cases.

The second pair is the write-completion edge against a load strobe and a read strobe. On that last busy cycle the bench always drives a load with a random address. The load must be absent from the following page image, and the following write must still last exactly WRITE_CYC cycles.

// File: rtl/pagewr_pkg.sv
// Package: shared types and constants for the page-mode write buffer.
// Assumes byte-wide data; the erased value of a cell is all ones.
package pagewr_pkg;
    localparam int          BYTE_W      = 8;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        PW_IDLE  = 2'd0,
        PW_LOAD  = 2'd1,
        PW_WRITE = 2'd2
    } pw_state_t;
endpackage

// File: rtl/pagewr_buf.sv
// Module: pagewr_buf
// Holds one page of bytes in flops. Reset and clear return every slot to
// the erased value, so slots left unloaded commit as 0xFF.
// Assumes wr_en_i and clr_i are never asserted together by the caller.
module pagewr_buf
    import pagewr_pkg::*;
#(
    parameter int OFF_W = 7,
    localparam int NBYTES = 1 << OFF_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [OFF_W-1:0]           off_i,
    input  logic [BYTE_W-1:0]          data_i,
    input  logic                       clr_i,
    output logic [NBYTES*BYTE_W-1:0]   page_o
);
    logic [BYTE_W-1:0] mem_q [NBYTES];

    // Slot storage: erase on reset or clear, else write the addressed slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            for (int i = 0; i < NBYTES; i++) mem_q[i] <= ERASED_BYTE;
        end else if (wr_en_i) begin
            mem_q[off_i] <= data_i;
        end
    end

    // Flatten the slots into the wide page image.
    for (genvar g = 0; g < NBYTES; g++) begin : g_pack
        assign page_o[g*BYTE_W +: BYTE_W] = mem_q[g];
    end

    AST_CLR_ERASES: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> (&page_o)); // R12
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (wr_en_i && !clr_i) |=> mem_q[$past(off_i)] == $past(data_i)); // R2
endmodule

// File: rtl/pagewr_tmr.sv
// Module: pagewr_tmr
// Interval timer. It counts clock edges while run_i is high and raises done_o
// on the LIMIT-th edge since run started or clr_i was last seen.
// Assumes LIMIT >= 1. The count returns to zero when done or idle.
module pagewr_tmr #(
    parameter int LIMIT = 16,
    localparam int CNT_W = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic done_o
);
    logic [CNT_W-1:0] cnt_q;

    assign done_o = run_i && !clr_i && (cnt_q == CNT_W'(LIMIT - 1));

    // Edge counter: restart on idle, clear or expiry; otherwise step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i || clr_i || done_o) cnt_q <= '0;
        else                                     cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/pagewr_stat.sv
// Module: pagewr_stat
// Polling status generator. While busy, the byte shows the inverted
// polarity bit in bit 7 and a toggle in bit 6 that flips per read.
// Assumes start_i pulses once, in the cycle before busy_i rises.
module pagewr_stat
    import pagewr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              busy_i,
    input  logic              rd_i,
    input  logic              pol_i,
    output logic [BYTE_W-1:0] status_o
);
    logic tog_q;

    // Toggle bit: cleared at write start, inverted on each busy read.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)   tog_q <= 1'b0;
        else if (busy_i && rd_i) tog_q <= ~tog_q;
    end

    assign status_o = busy_i ? {~pol_i, tog_q, 6'b0} : '0;

    AST_TOG_STEPS: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && rd_i) |=> (!busy_i || status_o[6] != $past(status_o[6]))); // R10
    AST_TOG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && !rd_i) |=> (!busy_i || $stable(status_o[6]))); // R10
endmodule

// File: rtl/pagewr_ctrl.sv
// Module: pagewr_ctrl (top)
// Page-mode write controller. It gathers byte loads into a page buffer and
// holds the page open while loads keep coming within LOAD_TMO_CYC edges.
// It then commits the page in one wide array write and stays busy for
// WRITE_CYC cycles, serving polling status reads.
// Assumes a synchronous host and one-cycle strobes. Both intervals are >= 1.
module pagewr_ctrl
    import pagewr_pkg::*;
#(
    parameter int ADDR_W       = 17,
    parameter int OFF_W        = 7,
    parameter int LOAD_TMO_CYC = 25000,
    parameter int WRITE_CYC    = 625000,
    localparam int PAGE_W = ADDR_W - OFF_W,
    localparam int NBYTES = 1 << OFF_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ld_stb_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [7:0]                data_i,
    input  logic                      rd_stb_i,
    output logic                      busy_o,
    output logic [7:0]                rd_status_o,
    output logic                      arr_we_o,
    output logic [PAGE_W-1:0]         arr_page_o,
    output logic [NBYTES*8-1:0]       arr_data_o
);
    pw_state_t         state_q;
    logic              ld_acc;
    logic              tmo_done;
    logic              wr_done;
    logic              start;
    logic [PAGE_W-1:0] page_q;
    logic              pol_q;

    assign ld_acc = ld_stb_i && (state_q != PW_WRITE);
    assign start  = (state_q == PW_LOAD) && tmo_done;
    assign busy_o = (state_q == PW_WRITE);

    // Load-window timer: restarted by every accepted load.
    pagewr_tmr #(.LIMIT(LOAD_TMO_CYC)) u_ld_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (state_q == PW_LOAD),
        .clr_i  (ld_stb_i),
        .done_o (tmo_done)
    );

    // Internal write timer: spans the busy period.
    pagewr_tmr #(.LIMIT(WRITE_CYC)) u_wr_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_o),
        .clr_i  (1'b0),
        .done_o (wr_done)
    );

    // Sequencer: idle -> loading -> writing -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PW_IDLE;
        end else begin
            unique case (state_q)
                PW_IDLE:  if (ld_acc)  state_q <= PW_LOAD;
                PW_LOAD:  if (start)   state_q <= PW_WRITE;
                PW_WRITE: if (wr_done) state_q <= PW_IDLE;
                default:               state_q <= PW_IDLE;
            endcase
        end
    end

    // Page number and polling polarity follow the last accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            pol_q  <= 1'b0;
        end else if (ld_acc) begin
            page_q <= addr_i[ADDR_W-1:OFF_W];
            pol_q  <= data_i[7];
        end
    end

    pagewr_buf #(.OFF_W(OFF_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (ld_acc),
        .off_i   (addr_i[OFF_W-1:0]),
        .data_i  (data_i),
        .clr_i   (wr_done),
        .page_o  (arr_data_o)
    );

    pagewr_stat u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .busy_i   (busy_o),
        .rd_i     (rd_stb_i),
        .pol_i    (pol_q),
        .status_o (rd_status_o)
    );

    assign arr_we_o   = wr_done;
    assign arr_page_o = page_q;

    AST_WE_INSIDE_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) arr_we_o |-> busy_o); // R8
    AST_BUSY_ENDS_ON_WE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> $past(arr_we_o)); // R8
    AST_LOAD_KEEPS_OPEN: assert property (@(posedge clk) disable iff (!rst_n) ld_acc |=> !busy_o); // R3
    AST_PAGE_FROZEN:     assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(arr_page_o)); // R11
    AST_POLL_STABLE:     assert property (@(posedge clk) disable iff (!rst_n) (busy_o && $past(busy_o)) |-> $stable(rd_status_o[7])); // R9
endmodule

// File: tb/pagewr_ctrl_tb.sv
// Bench for pagewr_ctrl: directed corner pages plus seeded random pages,
// checked against a byte-level model of the page buffer.
module pagewr_ctrl_tb;
    localparam int TMO = 12;
    localparam int WRC = 30;
    localparam int NB  = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_stb_i = 1'b0;
    logic [16:0] addr_i = '0;
    logic [7:0]  data_i = '0;
    logic        rd_stb_i = 1'b0;
    logic        busy_o;
    logic [7:0]  rd_status_o;
    logic        arr_we_o;
    logic [9:0]  arr_page_o;
    logic [NB*8-1:0] arr_data_o;

    int   n_chk = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;

    logic [7:0] exp_buf [NB];
    logic [9:0] exp_page;
    logic       exp_b7;
    logic       tog;

    always #4 clk = ~clk;

    pagewr_ctrl #(.LOAD_TMO_CYC(TMO), .WRITE_CYC(WRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ld_stb_i(ld_stb_i), .addr_i(addr_i),
        .data_i(data_i), .rd_stb_i(rd_stb_i), .busy_o(busy_o),
        .rd_status_o(rd_status_o), .arr_we_o(arr_we_o),
        .arr_page_o(arr_page_o), .arr_data_o(arr_data_o)
    );

    function automatic logic [7:0] exp_status(input logic b7, input logic t);
        return {~b7, t, 6'b0};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic erase_model();
        for (int i = 0; i < NB; i++) exp_buf[i] = 8'hFF;
    endtask

    // One load strobe; caller is at a negedge, returns at the next one.
    task automatic load_byte(input logic [16:0] a, input logic [7:0] d);
        ld_stb_i = 1'b1; addr_i = a; data_i = d; rd_stb_i = 1'($urandom % 2);
        @(negedge clk);
        ld_stb_i = 1'b0; rd_stb_i = 1'b0;
        exp_buf[a[6:0]] = d; exp_page = a[16:7]; exp_b7 = d[7];
        chk(busy_o == 1'b0, "R3 open after load", 32'(busy_o), 0);
    endtask

    // Idle cycles inside the window; status must read zero (R9, R11).
    task automatic idle(input int n);
        for (int j = 0; j < n; j++) begin
            rd_stb_i = 1'($urandom % 2);
            @(negedge clk);
            rd_stb_i = 1'b0;
            chk(busy_o == 1'b0 && rd_status_o == 8'h00, "R9 idle status/R3 window", 32'({busy_o, rd_status_o}), 0);
        end
    endtask

    // Let the window expire and follow the internal write to its end.
    task automatic finish_page();
        int bad;
        idle(TMO - 1);
        @(negedge clk);
        chk(busy_o == 1'b1, "R4 busy after timeout", 32'(busy_o), 1);
        tog = 1'b0;
        for (int b = 1; b <= WRC; b++) begin
            chk(busy_o == 1'b1, "R8 busy length", 32'(busy_o), 1);
            chk(rd_status_o == exp_status(exp_b7, tog), "R9 R10 status", 32'(rd_status_o), 32'(exp_status(exp_b7, tog)));
            chk(arr_we_o == (b == WRC), "R8 write strobe", 32'(arr_we_o), 32'(b == WRC));
            if (b == WRC) begin
                chk(arr_page_o == exp_page, "R7 page", 32'(arr_page_o), 32'(exp_page));
                bad = -1;
                for (int i = 0; i < NB; i++)
                    if (arr_data_o[i*8 +: 8] !== exp_buf[i] && bad < 0) bad = i;
                chk(bad < 0, "R2 R5 R6 R12 page image", bad < 0 ? 0 : 32'(arr_data_o[bad*8 +: 8]),
                    bad < 0 ? 0 : 32'(exp_buf[bad]));
            end
            rd_stb_i = 1'($urandom % 2);
            ld_stb_i = (b == WRC) ? 1'b1 : 1'($urandom % 3 == 0);  // R11 ignored loads
            addr_i = 17'($urandom); data_i = 8'($urandom);
            @(negedge clk);
            if (rd_stb_i) tog = ~tog;
            ld_stb_i = 1'b0; rd_stb_i = 1'b0;
        end
        chk(busy_o == 1'b0 && arr_we_o == 1'b0, "R8 busy ends", 32'({busy_o, arr_we_o}), 0);
        erase_model();
    endtask

    initial begin
        void'($urandom(32'd1234));
        erase_model();
        exp_page = '0; exp_b7 = 1'b0; tog = 1'b0;
        repeat (3) @(negedge clk);
        chk(busy_o == 0 && arr_we_o == 0 && rd_status_o == 0, "R1 reset", 32'({busy_o, arr_we_o, rd_status_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 0 && rd_status_o == 0, "R1 after reset", 32'({busy_o, rd_status_o}), 0);

        // Single byte: all other slots erased (R5).
        load_byte({10'h2A5, 7'd0}, 8'h3C);
        finish_page();

        // Overwrite with a maximal gap; last slot; polarity bit set (R3, R6).
        load_byte({10'h001, 7'd127}, 8'h11);
        idle(TMO - 1);
        load_byte({10'h001, 7'd127}, 8'h9E);
        idle(TMO - 1);
        load_byte({10'h001, 7'd5}, 8'hC4);
        finish_page();

        // Page changes mid-load: last address decides the page (R7).
        load_byte({10'h0F0, 7'd9}, 8'h01);
        load_byte({10'h3FF, 7'd10}, 8'h7F);
        load_byte({10'h155, 7'd11}, 8'h00);
        finish_page();

        // Random pages.
        for (int p = 0; p < 30; p++) begin
            logic [9:0] pg;
            int n;
            pg = 10'($urandom);
            n = 1 + int'($urandom % 20);
            for (int k = 0; k < n; k++) begin
                if ($urandom % 8 == 0) pg = 10'($urandom);
                load_byte({pg, 7'($urandom)}, 8'($urandom));
                if (k != n - 1) idle(int'($urandom % TMO));
            end
            finish_page();
        end

        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule